// File: doc/BRIEF.md
# Nibble BCD Arithmetic Logic Unit

A purely combinational 4-bit arithmetic logic unit for a processor that works on one decimal digit at a time. An operation select, two digit operands and the current flag nibble go in. A result digit, a write-enable and the updated flag nibble come out in the same cycle. The surrounding core keeps the flags in its own register and feeds them back on the next operation. This lets multi-digit work such as BCD addition, subtraction or halving run digit by digit through the carry or borrow flag.

The sixteen operations are grouped as follows. The binary arithmetic group has plain and chained addition and subtraction, a compare, and increment and decrement. The logic group has AND, OR, XOR and a bit test. The decimal group has a nine's complement, a decimal halving step that turns an incoming carry into "plus five", and two separate digit adjusts: one for use after an addition and one for use after a subtraction. A loop-counter decrement changes only the zero and auxiliary flags, so a carry or borrow chain survives it.

Top module: `nibble_bcd_alu`

## Requirements
- R1: With opSel 0 (plain add) or 1 (add with carry), result is (opA + opB + cin) mod 16. Here cin is 0 for opSel 0 and flagsIn bit 1 (carry) for opSel 1. Carry is set exactly when the true sum exceeds 15. Only the zero and carry flags change.
- R2: With opSel 2 (subtract) or 3 (subtract with borrow), result is (opA - opB - bin) mod 16. Here bin is 0 for opSel 2 and flagsIn bit 2 (borrow) for opSel 3. Borrow is set exactly when the true difference is below 0. Only the zero and borrow flags change.
- R3: With opSel 4, 5 or 6, result is opA AND, OR or XOR opB respectively. Only the zero flag changes.
- R4: With opSel 7 (compare), the zero and borrow flags change as for opSel 2, the other flags are kept, and writeEn is low.
- R5: With opSel 8 (bit test), the zero flag is set exactly when (opA AND opB) is 0, the other flags are kept, and writeEn is low.
- R6: With opSel 9 (increment), result is (opA + 1) mod 16, carry is set only for opA = 15, and only zero and carry change. With opSel 10 (decrement), result is (opA - 1) mod 16, borrow is set only for opA = 0, and only zero and borrow change.
- R7: With opSel 11 (counter decrement), result is (opA - 1) mod 16. Only the zero and auxiliary flags change. The auxiliary flag is set when opA was nonzero and cleared when opA was 0. Carry and borrow pass through untouched.
- R8: With opSel 12 (nine's complement), result is (9 - opA) mod 16. Only the zero flag changes.
- R9: With opSel 13 (decimal halving), result is floor(opA / 2) + (5 if flagsIn carry is set), mod 16. Carry-out equals bit 0 of opA. Only zero and carry change.
- R10: With opSel 14 (adjust after addition), when opA > 9 or the carry flag is set, result is (opA + 6) mod 16 and carry is set. Otherwise result is opA and carry is cleared. Only zero and carry change.
- R11: With opSel 15 (adjust after subtraction), when opA > 9 or the borrow flag is set, result is (opA + 10) mod 16 and borrow is set. Otherwise result is opA and borrow is cleared. Only zero and borrow change.
- R12: In both flag nibbles, bit 0 is zero, bit 1 carry, bit 2 borrow and bit 3 auxiliary. For every opSel, flagsOut bit 0 is set exactly when result is 0. writeEn is high for every opSel except 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation select, encodings as in R1 to R11 |
| opA | input | 4 | First operand digit (sole operand of single-operand operations) |
| opB | input | 4 | Second operand digit |
| flagsIn | input | 4 | Current flags: bit 0 zero, 1 carry, 2 borrow, 3 auxiliary |
| result | output | 4 | Result digit (flag source for compare and bit test) |
| flagsOut | output | 4 | Updated flags in the same bit order |
| writeEn | output | 1 | High when result should be written to the destination |

## Verification
The bench builds the unit with its default 4-bit digit width. At that width the whole input space is 16 operations times 16 times 16 operand pairs times 16 flag nibbles, so it is swept completely, one vector per clock. This covers every wrap point, every adjust threshold between 9 and 10, every carry-in and borrow-in combination, and every flag that must pass through untouched.

// File: rtl/nibble_alu_pkg.sv
package nibble_alu_pkg;

  localparam int OP_W   = 4;
  localparam int FLAG_N = 4;

  // flag bit positions inside the flag nibble
  localparam int FZ = 0;
  localparam int FC = 1;
  localparam int FB = 2;
  localparam int FA = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_CMP  = 4'd7,
    OP_BIT  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10,
    OP_DCNT = 4'd11,
    OP_CPL9 = 4'd12,
    OP_HALF = 4'd13,
    OP_ADJA = 4'd14,
    OP_ADJS = 4'd15
  } aluOp_e;

  typedef enum logic [3:0] {
    SRC_ADD,
    SRC_SUB,
    SRC_AND,
    SRC_OR,
    SRC_XOR,
    SRC_HALF,
    SRC_CPL,
    SRC_ADJA,
    SRC_ADJS
  } srcSel_e;

  // strobes from control to datapath
  typedef struct packed {
    srcSel_e           src;
    logic              useCarry;   // add consumes incoming carry
    logic              useBorrow;  // subtract consumes incoming borrow
    logic              unitB;      // second operand forced to one
    logic              writeEn;
    logic              auxPrior;   // aux flag reports operand was nonzero
    logic [FLAG_N-1:0] updMask;    // which flags take a new value
  } ctrlStrobes_t;

endpackage

// File: rtl/nibble_alu_ctrl.sv
module nibble_alu_ctrl
  import nibble_alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output ctrlStrobes_t    strobes
);

  localparam logic [FLAG_N-1:0] M_Z  = FLAG_N'(1) << FZ;
  localparam logic [FLAG_N-1:0] M_C  = FLAG_N'(1) << FC;
  localparam logic [FLAG_N-1:0] M_B  = FLAG_N'(1) << FB;
  localparam logic [FLAG_N-1:0] M_A  = FLAG_N'(1) << FA;

  always_comb begin
    strobes.src       = SRC_ADD;
    strobes.useCarry  = 1'b0;
    strobes.useBorrow = 1'b0;
    strobes.unitB     = 1'b0;
    strobes.writeEn   = 1'b1;
    strobes.auxPrior  = 1'b0;
    strobes.updMask   = M_Z;
    case (aluOp_e'(opSel))
      OP_ADD:  begin strobes.src = SRC_ADD; strobes.updMask = M_Z | M_C; end
      OP_ADC:  begin
        strobes.src = SRC_ADD; strobes.useCarry = 1'b1;
        strobes.updMask = M_Z | M_C;
      end
      OP_SUB:  begin strobes.src = SRC_SUB; strobes.updMask = M_Z | M_B; end
      OP_SBC:  begin
        strobes.src = SRC_SUB; strobes.useBorrow = 1'b1;
        strobes.updMask = M_Z | M_B;
      end
      OP_AND:  strobes.src = SRC_AND;
      OP_OR:   strobes.src = SRC_OR;
      OP_XOR:  strobes.src = SRC_XOR;
      OP_CMP:  begin
        strobes.src = SRC_SUB; strobes.writeEn = 1'b0;
        strobes.updMask = M_Z | M_B;
      end
      OP_BIT:  begin strobes.src = SRC_AND; strobes.writeEn = 1'b0; end
      OP_INC:  begin
        strobes.src = SRC_ADD; strobes.unitB = 1'b1;
        strobes.updMask = M_Z | M_C;
      end
      OP_DEC:  begin
        strobes.src = SRC_SUB; strobes.unitB = 1'b1;
        strobes.updMask = M_Z | M_B;
      end
      OP_DCNT: begin
        strobes.src = SRC_SUB; strobes.unitB = 1'b1;
        strobes.auxPrior = 1'b1; strobes.updMask = M_Z | M_A;
      end
      OP_CPL9: strobes.src = SRC_CPL;
      OP_HALF: begin strobes.src = SRC_HALF; strobes.updMask = M_Z | M_C; end
      OP_ADJA: begin strobes.src = SRC_ADJA; strobes.updMask = M_Z | M_C; end
      OP_ADJS: begin strobes.src = SRC_ADJS; strobes.updMask = M_Z | M_B; end
      default: strobes.updMask = M_Z;
    endcase
  end

endmodule

// File: rtl/nibble_alu_dp.sv
module nibble_alu_dp
  import nibble_alu_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  ctrlStrobes_t       strobes,
  input  logic [DIGIT_W-1:0] opA,
  input  logic [DIGIT_W-1:0] opB,
  input  logic [FLAG_N-1:0]  flagsIn,
  output logic [DIGIT_W-1:0] result,
  output logic [FLAG_N-1:0]  flagsOut
);

  localparam int                 EXT_W    = DIGIT_W + 1;
  localparam logic [DIGIT_W-1:0] DEC_MAX  = DIGIT_W'(9);
  localparam logic [DIGIT_W-1:0] FIX_ADD  = DIGIT_W'((1 << DIGIT_W) - 10);
  localparam logic [DIGIT_W-1:0] FIX_SUB  = DIGIT_W'(10);
  localparam logic [DIGIT_W-1:0] HALF_TEN = DIGIT_W'(5);

  logic [DIGIT_W-1:0] bEff;
  logic               cinEff, binEff;
  logic [EXT_W-1:0]   sumExt, diffExt;
  logic [DIGIT_W-1:0] halfVal, cplVal, adjAVal, adjSVal;
  logic               overRange, adjAHit, adjSHit;
  logic               carryNew, borrowNew;
  logic [FLAG_N-1:0]  newFlags;

  assign bEff    = strobes.unitB ? DIGIT_W'(1) : opB;
  assign cinEff  = strobes.useCarry  & flagsIn[FC];
  assign binEff  = strobes.useBorrow & flagsIn[FB];

  assign sumExt  = {1'b0, opA} + {1'b0, bEff} + EXT_W'(cinEff);
  assign diffExt = {1'b0, opA} - {1'b0, bEff} - EXT_W'(binEff);

  // decimal halving: previous digit's odd half arrives as carry
  assign halfVal = (opA >> 1) + (flagsIn[FC] ? HALF_TEN : '0);
  assign cplVal  = DEC_MAX - opA;

  assign overRange = opA > DEC_MAX;
  assign adjAHit   = overRange | flagsIn[FC];
  assign adjSHit   = overRange | flagsIn[FB];
  assign adjAVal   = adjAHit ? opA + FIX_ADD : opA;
  assign adjSVal   = adjSHit ? opA + FIX_SUB : opA;

  always_comb begin
    result    = sumExt[DIGIT_W-1:0];
    carryNew  = sumExt[DIGIT_W];
    borrowNew = diffExt[DIGIT_W];
    case (strobes.src)
      SRC_ADD:  result = sumExt[DIGIT_W-1:0];
      SRC_SUB:  result = diffExt[DIGIT_W-1:0];
      SRC_AND:  result = opA & opB;
      SRC_OR:   result = opA | opB;
      SRC_XOR:  result = opA ^ opB;
      SRC_HALF: begin result = halfVal; carryNew = opA[0]; end
      SRC_CPL:  result = cplVal;
      SRC_ADJA: begin result = adjAVal; carryNew = adjAHit; end
      SRC_ADJS: begin result = adjSVal; borrowNew = adjSHit; end
      default:  result = sumExt[DIGIT_W-1:0];
    endcase
  end

  always_comb begin
    newFlags     = flagsIn;
    newFlags[FZ] = (result == '0);
    newFlags[FC] = carryNew;
    newFlags[FB] = borrowNew;
    newFlags[FA] = strobes.auxPrior & (opA != '0);
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flagMerge
    assign flagsOut[i] = strobes.updMask[i] ? newFlags[i] : flagsIn[i];
  end

endmodule

// File: rtl/nibble_bcd_alu.sv
module nibble_bcd_alu
  import nibble_alu_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic [OP_W-1:0]    opSel,
  input  logic [DIGIT_W-1:0] opA,
  input  logic [DIGIT_W-1:0] opB,
  input  logic [FLAG_N-1:0]  flagsIn,
  output logic [DIGIT_W-1:0] result,
  output logic [FLAG_N-1:0]  flagsOut,
  output logic               writeEn
);

  ctrlStrobes_t strobes;

  nibble_alu_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  nibble_alu_dp #(.DIGIT_W(DIGIT_W)) u_dp (
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .flagsIn  (flagsIn),
    .result   (result),
    .flagsOut (flagsOut)
  );

  assign writeEn = strobes.writeEn;

endmodule

// File: rtl/nibble_bcd_alu_chk.sv
module nibble_bcd_alu_chk
  import nibble_alu_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input logic [OP_W-1:0]    opSel,
  input logic [DIGIT_W-1:0] opA,
  input logic [DIGIT_W-1:0] opB,
  input logic [FLAG_N-1:0]  flagsIn,
  input logic [DIGIT_W-1:0] result,
  input logic [FLAG_N-1:0]  flagsOut,
  input logic               writeEn
);

  aluOp_e op;
  assign op = aluOp_e'(opSel);

  always_comb begin
    // R12
    zero_tracks_result_chk: assert (flagsOut[FZ] == (result == '0));
    // R4
    cmp_no_write_chk: assert (!(op == OP_CMP && writeEn));
    // R5
    bit_keeps_flags_chk: assert (!(op == OP_BIT) ||
      (!writeEn && flagsOut[FA:FC] == flagsIn[FA:FC] &&
       flagsOut[FZ] == ((opA & opB) == '0)));
    // R7
    dcnt_keeps_chain_chk: assert (!(op == OP_DCNT) ||
      (flagsOut[FB:FC] == flagsIn[FB:FC] && flagsOut[FA] == (opA != '0)));
    // R3
    logic_only_zero_chk: assert (!(op == OP_AND || op == OP_OR || op == OP_XOR) ||
      flagsOut[FA:FC] == flagsIn[FA:FC]);
    // R9
    half_carry_lsb_chk: assert (!(op == OP_HALF) || flagsOut[FC] == opA[0]);
    // R10
    adja_wraps_chk: assert (!(op == OP_ADJA && opA > DIGIT_W'(9)) ||
      (flagsOut[FC] && result < DIGIT_W'(6)));
  end

endmodule

bind nibble_bcd_alu nibble_bcd_alu_chk #(.DIGIT_W(DIGIT_W)) u_chk (
  .opSel    (opSel),
  .opA      (opA),
  .opB      (opB),
  .flagsIn  (flagsIn),
  .result   (result),
  .flagsOut (flagsOut),
  .writeEn  (writeEn)
);

// File: tb/nibble_bcd_alu_tb.sv
module nibble_bcd_alu_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opSel = '0, opA = '0, opB = '0, flagsIn = '0;
  logic [3:0] result, flagsOut;
  logic       writeEn;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;  // 125 MHz

  nibble_bcd_alu u_dut (
    .opSel(opSel), .opA(opA), .opB(opB), .flagsIn(flagsIn),
    .result(result), .flagsOut(flagsOut), .writeEn(writeEn)
  );

  // expected model: returns {writeEn, flags[3:0], result[3:0]}
  function automatic logic [8:0] refModel(int op, int a, int b, logic [3:0] f);
    int r = 0; int we = 1; logic [3:0] nf = f; int t;
    case (op)
      0, 1: begin t = a + b + ((op == 1) ? int'(f[1]) : 0); r = t % 16; nf[1] = (t > 15); end
      2, 3, 7: begin
        t = a - b - ((op == 3) ? int'(f[2]) : 0);
        r = (t + 32) % 16; nf[2] = (t < 0); if (op == 7) we = 0;
      end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      8: begin r = a & b; we = 0; end
      9: begin r = (a + 1) % 16; nf[1] = (a == 15); end
      10: begin r = (a + 15) % 16; nf[2] = (a == 0); end
      11: begin r = (a + 15) % 16; nf[3] = (a != 0); end
      12: r = (9 - a + 16) % 16;
      13: begin r = (a / 2 + (f[1] ? 5 : 0)) % 16; nf[1] = a[0]; end
      14: begin
        if (a > 9 || f[1]) begin r = (a + 6) % 16; nf[1] = 1; end
        else begin r = a; nf[1] = 0; end
      end
      default: begin
        if (a > 9 || f[2]) begin r = (a + 10) % 16; nf[2] = 1; end
        else begin r = a; nf[2] = 0; end
      end
    endcase
    nf[0] = (r == 0);
    return {we[0], nf, r[3:0]};
  endfunction

  function automatic string tagOf(int op);
    case (op)
      0, 1: return "R1";
      2, 3: return "R2";
      4, 5, 6: return "R3";
      7: return "R4";
      8: return "R5";
      9, 10: return "R6";
      11: return "R7";
      12: return "R8";
      13: return "R9";
      14: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (op=%0d a=%0d b=%0d f=%b)",
               tag, what, act, exp, opSel, opA, opB, flagsIn);
    end
  endtask

  initial begin
    logic [8:0] e;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // starting state: all inputs zero selects plain add of 0+0
    @(negedge clk);
    check("R12", "initial zero flag", int'(flagsOut), 1);
    check("R1", "initial result", int'(result), 0);
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          for (int f = 0; f < 16; f++) begin
            @(posedge clk);
            #1;
            opSel = 4'(op); opA = 4'(a); opB = 4'(b); flagsIn = 4'(f);
            @(negedge clk);
            e = refModel(op, a, b, 4'(f));
            check("R12", "writeEn", int'(writeEn), int'(e[8]));
            check(tagOf(op), "flags", int'(flagsOut), int'(e[7:4]));
            if (e[8]) check(tagOf(op), "result", int'(result), int'(e[3:0]));
          end
        end
      end
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R12 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule